// File: doc/BRIEF.md
# Systolic Matrix Multiply Array

This block multiplies two square matrices of signed 8-bit values on a square grid of fixed-function multiply-accumulate cells. Each cell holds one result element. Operands move one hop per clock. Values from matrix A move rightward along the rows, and values from matrix B move downward along the columns. No cell ever sends data back toward the edge it came from. The caller presents one slice per clock for N consecutive clocks. Each slice is one column of A and the matching row of B. Delay lines at the west and north edges give each row and column its own extra delay: row or column i is held back i cycles. This way every pair A[i][k], B[k][j] meets inside cell (i,j) on the same clock.

The start pulse is the only control input. It clears every accumulator and marks the first slice. From there, a counter in the block counts clock edges. It decides when slice inputs are taken, and it raises a done flag once the last product has reached the far corner. All N*N results are then on a flat output bus. They stay there unchanged until the next accepted start.

Top module: `systolic_mm`

## Requirements
- R1: During and right after reset, `done_o` is low and every result field of `c_o` is zero.
- R2: After a run, result field f = i*N+j, at bits [f*AW +: AW] of `c_o` with AW = 2*DW+clog2(N)+1, holds the signed sum over k of A[i][k]*B[k][j].
- R3: Operands are taken on N consecutive rising edges, and the first of these is the edge that samples an accepted `start_i`. On the edge with index k, lane i of `a_col_i` (bits [i*DW +: DW]) carries A[i][k], and lane j of `b_row_i` carries B[k][j]. Both are two's complement.
- R4: An accepted start clears all accumulators, so no earlier run leaks into the new results, and `done_o` is low in the cycle after it.
- R5: `done_o` becomes high right after the (3N-2)th rising edge, counting the start edge as the first.
- R6: Values on `a_col_i` and `b_row_i` outside the N-edge operand window have no effect on the results.
- R7: While `done_o` is high and `start_i` stays low, `done_o` and `c_o` stay unchanged.
- R8: A start raised while a run is in progress is ignored. It neither shifts the done timing nor changes the results, and `done_o` is low whenever such a start is seen.
- R9: Extreme operands (all -128, or 127 against -128) give exact sums with no wraparound.
- R10: A start raised in a cycle where `done_o` is high is accepted and begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the only pacing signal for the cells |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run; sampled together with the first operand slice |
| a_col_i | input | N*DW | One column of A, lane i = row i |
| b_row_i | input | N*DW | One row of B, lane j = column j |
| done_o | output | 1 | Results on `c_o` are complete |
| c_o | output | N*N*AW | All result elements, field i*N+j |

## Verification
The end of one run and the acceptance of the next can fall on the same clock edge. The bench provokes this by raising start, with a new first slice, in the very cycle it first sees `done_o` high. The check is that done drops one cycle later, that the new latency is again 3N-2 edges, and that the new results carry nothing from the old matrices. A second overlap is a start raised in the middle of a run. The reference model discards that start, and the bench compares done timing and results against the model on every clock.

// File: rtl/systolic_pkg.sv
package systolic_pkg;

    typedef enum logic {
        SA_IDLE = 1'b0,
        SA_RUN  = 1'b1
    } sa_phase_e;

    // accumulator width: full product, growth for n terms, one guard bit
    function automatic int sa_acc_width(input int dw, input int n);
        return 2 * dw + $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import systolic_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic accept_o,
    output logic feed_o,
    output logic done_o
);

    localparam int LAT = 3 * N - 2;
    localparam int CW  = $clog2(LAT + 1) + 1;
    localparam logic [CW-1:0] LAT_C  = CW'(LAT);
    localparam logic [CW-1:0] FEED_C = CW'(N);

    typedef struct packed {
        sa_phase_e     phase;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = start_i && (st_q.phase == SA_IDLE);
        feed_o   = accept_o || ((st_q.phase == SA_RUN) && (st_q.cnt < FEED_C));
        if (accept_o) begin
            st_d.cnt   = CW'(1);
            st_d.done  = (LAT == 1);
            st_d.phase = (LAT == 1) ? SA_IDLE : SA_RUN;
        end else if (st_q.phase == SA_RUN) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_d.cnt == LAT_C) begin
                st_d.phase = SA_IDLE;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: SA_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

endmodule

// File: rtl/sa_skew.sv
module sa_skew #(
    parameter int DW    = 8,
    parameter int DEPTH = 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    logic [DEPTH-1:0][DW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_i;
        for (int s = 1; s < DEPTH; s++) begin
            sh_d[s] = sh_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q[DEPTH-1];

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
    parameter int DW = 8,
    parameter int AW = 19
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic signed [AW-1:0] acc_o
);

    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_x;
    logic signed [AW-1:0]   acc_d, acc_q;

    assign prod   = a_i * b_i;
    assign prod_x = {{(AW - 2 * DW){prod[2*DW-1]}}, prod};

    // a clear folds into the first accumulate, so no cycle is spent on it
    always_comb begin
        acc_d = (clr_i ? '0 : acc_q) + prod_x;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/systolic_mm.sv
module systolic_mm
    import systolic_pkg::*;
#(
    parameter  int N  = 4,
    parameter  int DW = 8,
    localparam int AW = sa_acc_width(DW, N)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [N*DW-1:0]   a_col_i,
    input  logic [N*DW-1:0]   b_row_i,
    output logic              done_o,
    output logic [N*N*AW-1:0] c_o
);

    // operand links between cells: a moves east, b moves south (N >= 2)
    typedef struct packed {
        logic [N-1:0][N-2:0][DW-1:0] a;
        logic [N-2:0][N-1:0][DW-1:0] b;
    } mesh_t;

    mesh_t mesh_d, mesh_q;

    logic accept;
    logic feed;

    logic [N-1:0][DW-1:0]        a_gate, b_gate;
    logic [N-1:0][DW-1:0]        a_edge, b_edge;
    logic [N-1:0][N-1:0][DW-1:0] pe_a, pe_b;
    logic [N-1:0][N-1:0][AW-1:0] pe_acc;

    sa_ctrl #(.N(N)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .accept_o (accept),
        .feed_o   (feed),
        .done_o   (done_o)
    );

    // operands outside the feed window are replaced by zero
    always_comb begin
        for (int i = 0; i < N; i++) begin
            a_gate[i] = feed ? a_col_i[i*DW +: DW] : '0;
            b_gate[i] = feed ? b_row_i[i*DW +: DW] : '0;
        end
    end

    // edge skew: lane i is held back i cycles
    for (genvar gi = 0; gi < N; gi++) begin : g_edge
        if (gi == 0) begin : g_direct
            assign a_edge[gi] = a_gate[gi];
            assign b_edge[gi] = b_gate[gi];
        end else begin : g_delay
            sa_skew #(.DW(DW), .DEPTH(gi)) u_skew_a (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .d_i    (a_gate[gi]),
                .q_o    (a_edge[gi])
            );
            sa_skew #(.DW(DW), .DEPTH(gi)) u_skew_b (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .d_i    (b_gate[gi]),
                .q_o    (b_edge[gi])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pe_a[i][0] = a_edge[i];
            for (int j = 1; j < N; j++) begin
                pe_a[i][j] = mesh_q.a[i][j-1];
            end
        end
        for (int j = 0; j < N; j++) begin
            pe_b[0][j] = b_edge[j];
            for (int i = 1; i < N; i++) begin
                pe_b[i][j] = mesh_q.b[i-1][j];
            end
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N - 1; j++) begin
                mesh_d.a[i][j] = pe_a[i][j];
            end
        end
        for (int i = 0; i < N - 1; i++) begin
            for (int j = 0; j < N; j++) begin
                mesh_d.b[i][j] = pe_b[i][j];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mesh_q <= '0;
        end else begin
            mesh_q <= mesh_d;
        end
    end

    for (genvar gr = 0; gr < N; gr++) begin : g_row
        for (genvar gc = 0; gc < N; gc++) begin : g_col
            sa_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .clr_i  (accept),
                .a_i    (pe_a[gr][gc]),
                .b_i    (pe_b[gr][gc]),
                .acc_o  (pe_acc[gr][gc])
            );
            assign c_o[(gr*N+gc)*AW +: AW] = pe_acc[gr][gc];
        end
    end

endmodule

// File: rtl/systolic_mm_chk.sv
module systolic_mm_chk #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 19
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              accept_i,
    input logic              done_i,
    input logic [N*N*AW-1:0] c_i
);

    localparam int LAT = 3 * N - 2;
    localparam int CW  = $clog2(LAT + 1) + 1;
    localparam logic [CW-1:0] LAT_C = CW'(LAT);

    // edges seen since the last accepted start, saturating at LAT
    logic [CW-1:0] chk_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_cnt <= '0;
        end else if (accept_i) begin
            chk_cnt <= CW'(1);
        end else if ((chk_cnt != '0) && (chk_cnt < LAT_C)) begin
            chk_cnt <= chk_cnt + CW'(1);
        end
    end

    assert_done_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_i) |-> (chk_cnt == LAT_C));

    assert_clear_on_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> !done_i);

    assert_hold_results_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !start_i) |=> (done_i && $stable(c_i)));

    assert_ignored_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !accept_i) |-> !done_i);

    assert_restart_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && done_i) |-> accept_i);

endmodule

bind systolic_mm systolic_mm_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_i (accept),
    .done_i   (done_o),
    .c_i      (c_o)
);

// File: tb/systolic_mm_tb.sv
module systolic_mm_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int DW  = 8;
    localparam int AW  = 2 * DW + $clog2(N) + 1;
    localparam int LAT = 3 * N - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*DW-1:0]   a_col = '0;
    logic [N*DW-1:0]   b_row = '0;
    logic              done;
    logic [N*N*AW-1:0] c;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int A [N][N];
    int B [N][N];

    // reference model state
    bit     m_busy, m_done;
    int     m_cnt;
    longint m_acc [N][N];

    systolic_mm #(.N(N), .DW(DW)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .a_col_i (a_col),
        .b_row_i (b_row),
        .done_o  (done),
        .c_o     (c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint field(input int i, input int j);
        return longint'($signed(c[(i*N+j)*AW +: AW]));
    endfunction

    function automatic longint expv(input int i, input int j);
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(A[i][k]) * longint'(B[k][j]);
        return s;
    endfunction

    // behavioural model: outer product of each accepted slice, edge counting
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_cnt  = 0;
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m_acc[i][j] = 0;
        end else begin
            if (start && !m_busy) begin
                for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m_acc[i][j] = 0;
                m_done = 1'b0;
                m_busy = 1'b1;
                m_cnt  = 0;
            end
            if (m_busy) begin
                if (m_cnt < N) begin
                    for (int i = 0; i < N; i++)
                        for (int j = 0; j < N; j++)
                            m_acc[i][j] += longint'($signed(a_col[i*DW +: DW])) *
                                           longint'($signed(b_row[j*DW +: DW]));
                end
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == m_done, "R5 done vs model", longint'(done), longint'(m_done));
            if (m_done) begin
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++)
                        chk(field(i, j) == m_acc[i][j], "R2 result vs model", field(i, j), m_acc[i][j]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic fill(input int seed, input int mode);
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < N; k++) begin
                case (mode)
                    1:       begin A[i][k] = -128; B[i][k] = -128; end
                    2:       begin A[i][k] = 127;  B[i][k] = -128; end
                    default: begin
                        A[i][k] = ((i * 7 + k * 13 + seed * 29) % 256) - 128;
                        B[i][k] = ((i * 5 + k * 17 + seed * 3 + 1) % 256) - 128;
                    end
                endcase
            end
        end
    endtask

    task automatic drive_slice(input int k);
        for (int i = 0; i < N; i++) begin
            a_col[i*DW +: DW] = DW'(A[i][k]);
            b_row[i*DW +: DW] = DW'(B[k][i]);
        end
    endtask

    task automatic set_garbage(input int s);
        for (int i = 0; i < N; i++) begin
            a_col[i*DW +: DW] = DW'(s * 37 + i * 11 + 90);
            b_row[i*DW +: DW] = DW'(s * 53 + i * 19 + 7);
        end
    endtask

    // called at a negedge; returns negedges from start until done is seen
    task automatic run(input bit garb, input bit poke, output int lat);
        lat = 0;
        start = 1'b1;
        drive_slice(0);
        for (int k = 1; k < N; k++) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            drive_slice(k);
            if (k == 1) chk(done == 1'b0, "R4 done low after start", longint'(done), 0);
        end
        @(negedge clk);
        lat++;
        start = 1'b0;
        if (garb) set_garbage(lat); else begin a_col = '0; b_row = '0; end
        if (poke) begin
            @(negedge clk);
            lat++;
            start = 1'b1;
            set_garbage(lat + 3);
            @(negedge clk);
            lat++;
            start = 1'b0;
        end
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
            if (garb) set_garbage(lat);
        end
    endtask

    task automatic check_results(input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(field(i, j) == expv(i, j), req, field(i, j), expv(i, j));
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", longint'(done), 0);
        chk(c == '0, "R1 results in reset", longint'(c != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
        chk(c == '0, "R1 results after reset", longint'(c != '0), 0);

        // R2 R3: plain run
        fill(1, 0);
        run(1'b0, 1'b0, lat);
        chk(lat == LAT, "R5 latency", lat, LAT);
        check_results("R2");
        check_results("R3 slice order");

        // R4 R6: new run over old results, junk outside the window
        fill(2, 0);
        run(1'b1, 1'b0, lat);
        chk(lat == LAT, "R5 latency run2", lat, LAT);
        check_results("R4 cleared");
        check_results("R6 window");

        // R8: start during a run
        fill(3, 0);
        run(1'b1, 1'b1, lat);
        chk(lat == LAT, "R8 latency unchanged", lat, LAT);
        check_results("R8 results");

        // R7: hold with junk on the operand lanes
        for (int r = 0; r < 6; r++) begin
            @(negedge clk);
            set_garbage(r + 40);
        end
        chk(done == 1'b1, "R7 done held", longint'(done), 1);
        check_results("R7 results held");

        // R9: extreme operands
        fill(0, 1);
        run(1'b0, 1'b0, lat);
        check_results("R9 all min");
        chk(field(N - 1, N - 1) == longint'(N) * 16384, "R9 corner", field(N - 1, N - 1), longint'(N) * 16384);
        fill(0, 2);
        run(1'b0, 1'b0, lat);
        check_results("R9 max x min");

        // R10: start in the cycle done is high
        chk(done == 1'b1, "R10 done before restart", longint'(done), 1);
        fill(4, 0);
        run(1'b0, 1'b0, lat);
        chk(lat == LAT, "R10 latency", lat, LAT);
        check_results("R10 results");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule